// File: doc/BRIEF.md
# Suspend Modulation Power Controller

This block throttles a processor by driving an active-low suspend line with a programmable duty cycle. It treats the processor as idle by default. While modulation runs, suspend is held asserted for a programmed number of timebase ticks, then released for another programmed number, and this repeats. The ratio of the two counts sets the effective clock rate. One tick is one 32 µs interval, supplied as a single-cycle strobe.

When there is activity, the processor runs at full speed for a while. An unmasked interrupt, an access to the speaker/system control port, or a software speedup command each reload an interrupt speedup timer. A video access reloads a separate video speedup timer. A system-management interrupt either reloads the interrupt timer or sets a latch, selected by a configuration bit. The latch holds full speed until software reads the speedup-disable register. While any timer is nonzero or the latch is set, suspend stays released. Once all of them clear, modulation restarts at the beginning of its asserted phase.

Registers are written through one port: `wr_addr` selects the register and `wr_data` carries the value. The register addresses are: 0 for configuration, 1 for the asserted count, 2 for the released count, 3 for the interrupt speedup count, 4 for the video speedup count, and 5 for the software speedup trigger. The trigger's data is ignored.

Top module: `susp_mod_ctrl`

## Requirements
- R1: Configuration bit 2 is the global power-management enable. While it is 0, `susp_n` is 1, both speedup timers and the SMI latch are held clear, and events load nothing. After reset all registers are 0 and `susp_n` is 1.
- R2: Configuration bit 0 enables modulation. While it is 0, `susp_n` stays 1.
- R3: While modulation runs and no speedup is active, `susp_n` is 0 for exactly A ticks and then 1 for exactly D ticks, repeating. A is the asserted count (address 1) and D is the released count (address 2).
- R4: If A = 0, `susp_n` is never driven to 0. If D = 0 and A > 0, `susp_n` stays 0 continuously.
- R5: An `ev_irq` or `ev_port61` pulse loads the interrupt speedup timer from the count at address 3. The timer decrements once per tick, and `susp_n` stays 1 while the timer is nonzero.
- R6: An `ev_video` pulse loads the video speedup timer from the count at address 4. `susp_n` stays 1 while that timer is nonzero.
- R7: An event that arrives while its timer is running reloads the timer to the full count. A load takes priority over a decrement in the same cycle.
- R8: With configuration bit 1 = 0, an `ev_smi` pulse loads the interrupt speedup timer.
- R9: With configuration bit 1 = 1 and bit 0 = 1, an `ev_smi` pulse sets a latch that holds `susp_n` at 1. A `smi_dis_rd` strobe clears the latch. No read data exists, and the latch does not time out.
- R10: A `smi_dis_rd` strobe while configuration bit 0 is 0 has no effect: a set latch stays set.
- R11: A write to address 5 loads the interrupt speedup timer, whatever the data.
- R12: When modulation starts or resumes after a speedup, the first output cycle is in the asserted phase, so `susp_n` is 0 at once if A > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32 µs timebase strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ev_irq | input | 1 | Unmasked interrupt event pulse |
| ev_port61 | input | 1 | System control port access pulse |
| ev_smi | input | 1 | System-management interrupt pulse |
| ev_video | input | 1 | Video access pulse |
| smi_dis_rd | input | 1 | Read strobe of the speedup-disable register |
| susp_n | output | 1 | Active-low processor suspend |

## Verification
The hardest state to reach is an SMI latch that software tried to clear while modulation was switched off. Reaching it needs a specific order of events. The bench sets latch mode, fires an SMI, clears only the modulation enable bit, issues the read strobe, and then re-enables modulation. At that point it checks that the line still shows full speed, and only a second read lets throttling resume. The duty cycle is swept over every asserted and released count from 0 to 4 with a tick on every cycle, so each phase length can be counted exactly.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG   = 3'd0,
        A_ON    = 3'd1,
        A_OFF   = 3'd2,
        A_IRQ   = 3'd3,
        A_VID   = 3'd4,
        A_SWSPD = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic gpm_en;          // bit 2
        logic smi_latch_mode;  // bit 1
        logic mod_en;          // bit 0
    } cfg_t;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } phase_e;

    function automatic logic reached(input logic [CNT_W-1:0] cur,
                                     input logic [CNT_W-1:0] lim);
        logic [CNT_W:0] nxt;
        nxt = {1'b0, cur} + 1'b1;
        return nxt >= {1'b0, lim};
    endfunction

endpackage

// File: rtl/susp_cfg_regs.sv
module susp_cfg_regs
    import susp_mod_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output cfg_t              cfg,
    output logic [CW-1:0]     on_cnt,
    output logic [CW-1:0]     off_cnt,
    output logic [CW-1:0]     irq_reload,
    output logic [CW-1:0]     vid_reload,
    output logic              sw_spd
);
    reg_addr_e addr;
    assign addr   = reg_addr_e'(wr_addr);
    assign sw_spd = wr_en && (addr == A_SWSPD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            on_cnt     <= '0;
            off_cnt    <= '0;
            irq_reload <= '0;
            vid_reload <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG:   cfg        <= cfg_t'(wr_data[2:0]);
                A_ON:    on_cnt     <= wr_data;
                A_OFF:   off_cnt    <= wr_data;
                A_IRQ:   irq_reload <= wr_data;
                A_VID:   vid_reload <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/susp_speedup_timer.sv
module susp_speedup_timer
    import susp_mod_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] reload,
    input  logic          tick,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (load)
            cnt <= reload;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: a load always wins and takes the full count
    p_reload_full_r7: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt == $past(reload)));

    // R5: one step down per tick, never below zero
    p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/susp_duty_gen.sv
module susp_duty_gen
    import susp_mod_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] on_cnt,
    input  logic [CW-1:0] off_cnt,
    output logic          hold_susp
);
    phase_e        ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph  <= PH_ON;
            cnt <= '0;
        end else if (tick) begin
            if (ph == PH_ON) begin
                if (reached(cnt, on_cnt)) begin
                    cnt <= '0;
                    if (off_cnt != '0) ph <= PH_OFF;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (reached(cnt, off_cnt)) begin
                    ph  <= PH_ON;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign hold_susp = run && (ph == PH_ON) && (on_cnt != '0);

    // R3: phase only moves on a tick
    p_phase_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(ph));

    // R12: stopping rewinds to the start of the asserted phase
    p_restart_on_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ph == PH_ON && cnt == '0));
endmodule

// File: rtl/susp_mod_ctrl.sv
module susp_mod_ctrl
    import susp_mod_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic              ev_irq,
    input  logic              ev_port61,
    input  logic              ev_smi,
    input  logic              ev_video,
    input  logic              smi_dis_rd,
    output logic              susp_n
);
    cfg_t          cfg;
    logic [CW-1:0] on_cnt, off_cnt, irq_reload, vid_reload;
    logic          sw_spd;
    logic          irq_busy, vid_busy, smi_hold;
    logic          irq_load, vid_load, run, hold_susp;

    susp_cfg_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .on_cnt(on_cnt), .off_cnt(off_cnt),
        .irq_reload(irq_reload), .vid_reload(vid_reload), .sw_spd(sw_spd)
    );

    assign irq_load = cfg.gpm_en &&
        (ev_irq || ev_port61 || sw_spd || (ev_smi && !cfg.smi_latch_mode));
    assign vid_load = cfg.gpm_en && ev_video;

    susp_speedup_timer #(.CW(CW)) u_irq_tmr (
        .clk(clk), .rst(rst), .clr(!cfg.gpm_en), .load(irq_load),
        .reload(irq_reload), .tick(tick), .busy(irq_busy)
    );

    susp_speedup_timer #(.CW(CW)) u_vid_tmr (
        .clk(clk), .rst(rst), .clr(!cfg.gpm_en), .load(vid_load),
        .reload(vid_reload), .tick(tick), .busy(vid_busy)
    );

    // SMI latch: set wins over the clearing read; read ignored when modulation is off
    always_ff @(posedge clk) begin
        if (rst || !cfg.gpm_en)
            smi_hold <= 1'b0;
        else if (ev_smi && cfg.smi_latch_mode && cfg.mod_en)
            smi_hold <= 1'b1;
        else if (smi_dis_rd && cfg.mod_en)
            smi_hold <= 1'b0;
    end

    assign run = cfg.gpm_en && cfg.mod_en && !irq_busy && !vid_busy && !smi_hold;

    susp_duty_gen #(.CW(CW)) u_duty (
        .clk(clk), .rst(rst), .run(run), .tick(tick),
        .on_cnt(on_cnt), .off_cnt(off_cnt), .hold_susp(hold_susp)
    );

    assign susp_n = !hold_susp;

    // R5: a running speedup timer means full speed
    p_speedup_full_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_busy || vid_busy) |-> susp_n);

    // R10: latch survives a read while modulation is disabled
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (smi_hold && cfg.gpm_en && !cfg.mod_en) |=> smi_hold);

    // R1: global disable clears every speedup source
    p_gpm_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg.gpm_en |=> (!irq_busy && !vid_busy && !smi_hold));
endmodule

// File: tb/tb_susp_mod_ctrl.sv
module tb_susp_mod_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ev_irq = 1'b0, ev_port61 = 1'b0, ev_smi = 1'b0, ev_video = 1'b0;
    logic       smi_dis_rd = 1'b0;
    logic       susp_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    susp_mod_ctrl dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_irq(ev_irq), .ev_port61(ev_port61),
        .ev_smi(ev_smi), .ev_video(ev_video), .smi_dis_rd(smi_dis_rd),
        .susp_n(susp_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // 0 irq, 1 port61, 2 smi, 3 video, 4 disable read
    task automatic pulse(input int k);
        case (k)
            0: ev_irq = 1'b1;
            1: ev_port61 = 1'b1;
            2: ev_smi = 1'b1;
            3: ev_video = 1'b1;
            default: smi_dis_rd = 1'b1;
        endcase
        @(negedge clk);
        ev_irq = 1'b0; ev_port61 = 1'b0; ev_smi = 1'b0;
        ev_video = 1'b0; smi_dis_rd = 1'b0;
    endtask

    task automatic run_high(input int lim, output int n);
        n = 0;
        while (susp_n && n < lim) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_low(input int w, output int n);
        n = 0;
        for (int i = 0; i < w; i++) begin
            if (!susp_n) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n, w, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset susp_n", int'(susp_n), 1);

        // R3 R4 R12: duty sweep over asserted/released counts 0..4
        for (int a = 0; a <= 4; a++) begin
            for (int d = 0; d <= 4; d++) begin
                wr(0, 4);
                wr(1, a);
                wr(2, d);
                wr(0, 5);
                if (a > 0) chk("R12 first cycle asserted", int'(susp_n), 0);
                w = (a + d == 0) ? 10 : 2 * (a + d);
                exp = (a == 0) ? 0 : ((d == 0) ? w : 2 * a);
                count_low(w, n);
                chk((a == 0 || d == 0) ? "R4 degenerate duty" : "R3 duty count", n, exp);
            end
        end

        // R2: modulation bit clear keeps full speed
        wr(1, 2); wr(2, 2); wr(3, 5); wr(4, 7);
        wr(0, 4);
        count_low(20, n);
        chk("R2 mod disabled low cycles", n, 0);

        // R5 interrupt and port events
        wr(0, 5);
        pulse(0); run_high(40, n); chk("R5 irq speedup length", n, 5);
        pulse(1); run_high(40, n); chk("R5 port61 speedup length", n, 5);
        // R7 reload mid-way
        pulse(0); @(negedge clk); @(negedge clk);
        pulse(0); run_high(40, n); chk("R7 reload full count", n, 5);
        // R6 video
        pulse(3); run_high(40, n); chk("R6 video speedup length", n, 7);
        // R11 software speedup
        wr(5, 8'hA5); run_high(40, n); chk("R11 software speedup length", n, 5);
        // R8 SMI timer mode
        pulse(2); run_high(40, n); chk("R8 smi timer mode length", n, 5);

        // R9 SMI latch mode
        wr(0, 7);
        pulse(2); run_high(50, n); chk("R9 latch holds full speed", n, 50);
        pulse(4); chk("R9 read releases latch", int'(susp_n), 0);

        // R10 read while modulation disabled is ignored
        pulse(2);
        wr(0, 6);
        pulse(4);
        wr(0, 7);
        run_high(30, n); chk("R10 latch survives disabled read", n, 30);
        pulse(4); chk("R10 later read releases", int'(susp_n), 0);

        // R1 global enable off: no throttle, events ignored, latch cleared
        wr(0, 1);
        count_low(20, n); chk("R1 gpm off low cycles", n, 0);
        pulse(0); pulse(3);
        wr(0, 5);
        chk("R1 events ignored while gpm off", int'(susp_n), 0);
        wr(0, 7); pulse(2);
        wr(0, 3);
        wr(0, 7);
        chk("R1 gpm off clears latch", int'(susp_n), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule